// File: doc/BRIEF.md
# Eight-Pin Bidirectional Port with Pull-Up Control

This block provides a group of general-purpose pins under the control of a small register bus. Two writable registers decide how each pin behaves. One holds the level each pin should drive. The other selects whether each pin drives or listens. A third, read-only location shows the level actually present on each pad, whichever way the pin is configured.

Each pin produces three pad controls: a drive value, a drive enable and a pull-up enable. When a pin is set to drive, its level bit sets the pad high or low. When a pin is set to listen, the same level bit instead turns the weak pull-up on or off. Pad inputs pass through a two-stage synchronizer before they can be read, so reads are free of metastability.

Bus writes take effect at the clock edge on which they are presented. Reads are combinational from the currently addressed location.

Top module: `pinbank`

## Requirements
- R1: While reset is held, and on leaving it, the level register and the direction register are 0. All pins are therefore inputs, with pad_oe, pad_pu and pad_out all 0.
- R2: A write with bus_addr = 0 loads the level register from bus_wdata at that clock edge. A read at address 0 returns the level register.
- R3: A write with bus_addr = 1 loads the direction register from bus_wdata at that clock edge. A read at address 1 returns the direction register.
- R4: For each pin, pad_oe is 1 exactly when its direction bit is 1, which makes the pin an output.
- R5: For an output pin, pad_out equals its level bit, so 1 drives high and 0 drives low. For an input pin, pad_out is 0.
- R6: For each pin, pad_pu is 1 only when the direction bit is 0 and the level bit is 1. An output pin never has its pull-up on.
- R7: A read at address 2 returns the value pad_in had two clock edges earlier. This holds whatever the direction setting.
- R8: A write with bus_addr = 2 changes no register and no pad control.
- R9: Address 3 reads as 0, and a write to it changes no register and no pad control.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 2 | Register select: 0 level, 1 direction, 2 pin input, 3 unused |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rd_data | output | 8 | Read data for the addressed location |
| pad_in | input | 8 | Asynchronous pad levels |
| pad_out | output | 8 | Level to drive on each pad |
| pad_oe | output | 8 | Drive enable for each pad |
| pad_pu | output | 8 | Pull-up enable for each pad |

## Verification
The assertions check several rules on every cycle:
- a direction write appears on pad_oe at the next cycle;
- a level write shows on every enabled driver;
- pull-up and drive enable are never both on for a pin;
- writes to the pin-input and unused addresses leave all pad controls unchanged;
- pin-input reads match pad_in from two edges earlier.

Only the bench's scenarios can show the following:
- readback of both writable registers across mixed directions;
- that the pull-up really follows the level bit when a pin is switched between input and output;
- that reading back the writable registers after writes to the pin-input address shows their contents were untouched.

// File: rtl/pinbank_pkg.sv
// Shared definitions for the pin bank: register map and bus address width.
// Assumes a two-bit address space with one location left unused.
package pinbank_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_LEVEL = 2'd0,
        SEL_DIR   = 2'd1,
        SEL_PIN   = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/pinbank_regs.sv
// Writable configuration registers of the pin bank (level and direction).
// Assumes one write per cycle; all other addresses leave the registers untouched.
module pinbank_regs
    import pinbank_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  level_q,
    output logic [WIDTH-1:0]  dir_q
);
    // Load the level register on a write to its address; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            level_q <= '0;
        else if (wr && addr == SEL_LEVEL)
            level_q <= wdata;
    end

    // Load the direction register on a write to its address; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dir_q <= '0;
        else if (wr && addr == SEL_DIR)
            dir_q <= wdata;
    end
endmodule

// File: rtl/pinbank_sync.sv
// Multi-stage synchronizer for the pad input levels.
// Assumes STAGES >= 1; the last stage feeds the pin-input read path.
module pinbank_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // First stage captures the raw pad levels.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain_q[0] <= '0;
        else
            chain_q[0] <= async_in;
    end

    genvar s;
    generate
        for (s = 1; s < STAGES; s++) begin : g_stage
            // Each later stage re-times the stage before it.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chain_q[s] <= '0;
                else
                    chain_q[s] <= chain_q[s-1];
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/pinbank_drive.sv
// Per-pin pad control decode: drive value, drive enable and pull-up enable.
// Assumes the level bit doubles as the pull-up request for input pins.
module pinbank_drive #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] level,
    input  logic [WIDTH-1:0] dir,
    output logic [WIDTH-1:0] drv_val,
    output logic [WIDTH-1:0] drv_en,
    output logic [WIDTH-1:0] pull_en
);
    genvar p;
    generate
        for (p = 0; p < WIDTH; p++) begin : g_pin
            // Decode one pin's pad controls from its direction and level bits.
            always_comb begin
                drv_en[p]  = dir[p];
                drv_val[p] = dir[p] & level[p];
                pull_en[p] = ~dir[p] & level[p];
            end
        end
    endgenerate
endmodule

// File: rtl/pinbank.sv
// Top of the pin bank: registers, input synchronizer, pad decode and read mux.
// Assumes a single-cycle bus where reads are combinational from bus_addr.
module pinbank
    import pinbank_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rd_data,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_pu
);
    logic [WIDTH-1:0] level_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] pin_sync;

    pinbank_regs #(.WIDTH(WIDTH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .level_q (level_q),
        .dir_q   (dir_q)
    );

    pinbank_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    pinbank_drive #(.WIDTH(WIDTH)) u_drive (
        .level   (level_q),
        .dir     (dir_q),
        .drv_val (pad_out),
        .drv_en  (pad_oe),
        .pull_en (pad_pu)
    );

    // Select the addressed location for the read bus.
    always_comb begin
        case (bus_addr)
            SEL_LEVEL: bus_rd_data = level_q;
            SEL_DIR:   bus_rd_data = dir_q;
            SEL_PIN:   bus_rd_data = pin_sync;
            default:   bus_rd_data = '0;
        endcase
    end
endmodule

// File: rtl/pinbank_chk.sv
// Property checker for the pin bank, bound to every instance of the top.
// Assumes the default two-stage input synchronizer for the read-latency check.
module pinbank_chk
    import pinbank_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [WIDTH-1:0]  bus_wdata,
    input logic [WIDTH-1:0]  bus_rd_data,
    input logic [WIDTH-1:0]  pad_in,
    input logic [WIDTH-1:0]  pad_out,
    input logic [WIDTH-1:0]  pad_oe,
    input logic [WIDTH-1:0]  pad_pu
);
    logic [1:0] live_cnt;

    // Count edges since reset, saturating, to guard history-based checks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            live_cnt <= '0;
        else if (live_cnt != 2'd3)
            live_cnt <= live_cnt + 2'd1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0 && pad_pu == '0 && pad_out == '0));

    // R4
    dir_to_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SEL_DIR) |=> (pad_oe == $past(bus_wdata)));

    // R5
    level_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SEL_LEVEL) |=> (((pad_out ^ $past(bus_wdata)) & pad_oe) == '0));

    // R6
    pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu & pad_oe) == '0));

    // R7
    pin_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt >= 2'd2 && bus_addr == SEL_PIN) |-> (bus_rd_data == $past(pad_in, 2)));

    // R8
    pin_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SEL_PIN) |=> ($stable(pad_oe) && $stable(pad_pu) && $stable(pad_out)));

    // R9
    none_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SEL_NONE) |=> ($stable(pad_oe) && $stable(pad_pu) && $stable(pad_out)));

    // R9
    none_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == SEL_NONE) |-> (bus_rd_data == '0));
endmodule

bind pinbank pinbank_chk #(.WIDTH(WIDTH)) u_pinbank_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rd_data (bus_rd_data),
    .pad_in      (pad_in),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .pad_pu      (pad_pu)
);

// File: tb/pinbank_bench.sv
// Self-checking bench for the pin bank: directed corners plus seeded random traffic.
module pinbank_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rd_data;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;
    logic [7:0] pad_pu;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [7:0] m_level = 8'h00;
    logic [7:0] m_dir   = 8'h00;
    logic [7:0] m_s1    = 8'h00;
    logic [7:0] m_s2    = 8'h00;

    always #4 clk = ~clk;

    pinbank u_pinbank (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rd_data (bus_rd_data),
        .pad_in      (pad_in),
        .pad_out     (pad_out),
        .pad_oe      (pad_oe),
        .pad_pu      (pad_pu)
    );

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return m_level;
            2'd1:    return m_dir;
            2'd2:    return m_s2;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string read_tag(input logic [1:0] a);
        case (a)
            2'd0:    return "R2";
            2'd1:    return "R3";
            2'd2:    return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%02h exp=%02h", req, act, exp);
        end
    endtask

    // One bus cycle: drive at the falling edge, update model at the rising edge, check after it.
    task automatic step(input logic [1:0] a, input logic w, input logic [7:0] d, input logic [7:0] pin);
        @(negedge clk);
        bus_addr = a; bus_wr = w; bus_wdata = d; pad_in = pin;
        @(posedge clk);
        if (w && a == 2'd0) m_level = d;
        if (w && a == 2'd1) m_dir = d;
        m_s2 = m_s1;
        m_s1 = pin;
        #1;
        chk(read_tag(a), bus_rd_data, exp_read(a));
        chk("R4", pad_oe, m_dir);
        chk("R5", pad_out, m_level & m_dir);
        chk("R6", pad_pu, m_level & ~m_dir);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: state while reset is held
        chk("R1", pad_oe, 8'h00);
        chk("R1", pad_pu, 8'h00);
        chk("R1", pad_out, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: registers read zero right after reset
        step(2'd0, 1'b0, 8'h00, 8'h00);
        chk("R1", bus_rd_data, 8'h00);
        step(2'd1, 1'b0, 8'h00, 8'h00);
        // R6: all inputs, level bits become pull-ups
        step(2'd0, 1'b1, 8'hA5, 8'h00);
        // R4 R5: half the pins to output, the rest keep pull-ups
        step(2'd1, 1'b1, 8'h0F, 8'h00);
        // R7: pin level readable on outputs and inputs
        step(2'd2, 1'b0, 8'h00, 8'h3C);
        step(2'd2, 1'b0, 8'h00, 8'hC3);
        step(2'd2, 1'b0, 8'h00, 8'hC3);
        // R8: write to pin-input address, then read back both registers
        step(2'd2, 1'b1, 8'hFF, 8'h00);
        step(2'd0, 1'b0, 8'h00, 8'h00);
        chk("R8", bus_rd_data, 8'hA5);
        step(2'd1, 1'b0, 8'h00, 8'h00);
        chk("R8", bus_rd_data, 8'h0F);
        // R9: unused address ignores writes and reads zero
        step(2'd3, 1'b1, 8'h5A, 8'h00);
        step(2'd1, 1'b0, 8'h00, 8'h00);
        chk("R9", bus_rd_data, 8'h0F);
        // R5: all outputs, drive follows level
        step(2'd1, 1'b1, 8'hFF, 8'h00);
        step(2'd0, 1'b1, 8'h96, 8'hFF);
        // Seeded random traffic
        void'($urandom(32'd4242));
        for (int i = 0; i < 600; i++) begin
            step(2'($urandom % 4), 1'($urandom % 2), 8'($urandom), 8'($urandom));
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=00 exp=01");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule